// File: doc/BRIEF.md
# Paged Memory Mapper

This block translates the 16-bit address of a small CPU into a wider physical RAM address. The 64 KiB CPU space is cut into sixteen 4 KiB slots, and each slot owns a page-number register. When translation is active, a CPU access in one of the expansion RAM slots is steered to whichever physical 4 KiB page that slot's register names; every other slot, and every slot while translation is off, passes through to its own address unchanged.

Software controls the block through two single-bit CRU locations. The bit at the CRU base makes the sixteen page registers visible as word locations in a register window at CPU addresses 0x4000 to 0x401E (slot n at 0x4000 + 2n); the bit one CRU location higher turns translation on. A page number is written with its low eight bits in the high byte of the word and its upper bits in the low byte, and registers read back in the same layout, which lets software detect the card and size its memory by aliasing.

A small state machine holds the two control bits as four named states: MM_IDLE (registers hidden, no translation), MM_SETUP (registers visible, no translation), MM_MAPPED (registers hidden, translating) and MM_MAP_SETUP (registers visible, translating). A CRU write to the visibility bit takes the transitions EN_ON or EN_OFF between IDLE/SETUP and between MAPPED/MAP_SETUP; a CRU write to the mapping bit takes MAP_ON or MAP_OFF between IDLE/MAPPED and between SETUP/MAP_SETUP. Any other CRU write leaves the state where it is.

Top module: `pgmap_top`

## Requirements
- R1: After reset the state is MM_IDLE (both CRU bits read 0, `mapped` low) and every slot register holds its own slot index, so slot n reads back as the word {n, 8'h00}.
- R2: A CRU write of 1 to the base address (default 0x1E00) makes the register window visible from the next cycle; a write of 0 hides it. `reg_hit` is high only while visible and `cpu_addr` lies in 0x4000–0x401F.
- R3: A word write into the visible window at 0x4000 + 2n loads slot n with page {wdata[7:0], wdata[15:8]} truncated to PAGE_W bits; reading it returns the page with its bits 7:0 in the high byte and bits 15:8 in the low byte, unimplemented bits reading 0.
- R4: A CPU write to 0x4000–0x401F while the window is hidden changes no register.
- R5: With translation off (CRU base+2 bit clear), `phys_addr` equals `cpu_addr` zero-extended and `mapped` is low for every address.
- R6: With translation on, an address in slots 0x2, 0x3 or 0xA–0xF yields `phys_addr` = {page, cpu_addr[11:0]} and `mapped` high.
- R7: Slots 0x0, 0x1 and 0x4–0x9 are never translated, whatever their register holds.
- R8: CRU writes to addresses other than base and base+2 change nothing; `cru_rbit` returns the visibility bit at base, the mapping bit at base+2, and 0 elsewhere.
- R9: A register or CRU write takes effect on the cycle after the clock edge that captures it; outputs are combinational from the inputs and that state.
- R10: Writing 0x0200 to 0x4004 restores slot 0x2 to page 2, giving pass-through results for 0x2000–0x2FFF even with translation on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cru_wr | input | 1 | CRU single-bit write strobe |
| cru_addr | input | 16 | CRU byte address of the bit |
| cru_wbit | input | 1 | CRU bit value to write |
| cru_rbit | output | 1 | CRU bit read back at cru_addr |
| cpu_addr | input | 16 | CPU byte address |
| cpu_we | input | 1 | CPU word write strobe |
| cpu_wdata | input | 16 | CPU write data |
| reg_hit | output | 1 | Access falls in the visible register window |
| reg_rdata | output | 16 | Register read data, 0 when not a hit |
| phys_addr | output | PAGE_W+12 | Physical byte address |
| mapped | output | 1 | Translation applied to this address |

## Verification
Every output is combinational from the inputs and the stored state, so address, read-data and CRU read-back results are due in the same cycle the address is presented, and the bench samples them a quarter period after driving. Register and CRU writes are captured by one clock edge and become visible from the following cycle; the bench drives each write on a falling edge, lets one rising edge capture it, removes the strobe, and only then sweeps the affected outputs. A page-size probe through a bench RAM that aliases after 32 pages exercises the full write, translate, and read-back path.

// File: rtl/mm_pkg.sv
package mm_pkg;

    localparam int CPU_AW    = 16;
    localparam int SLOT_BITS = 4;
    localparam int NSLOT     = 1 << SLOT_BITS;
    localparam int OFFS_W    = CPU_AW - SLOT_BITS;

    // Base of the register window and the number of address bits it spans
    localparam logic [CPU_AW-1:0] WIN_BASE = 16'h4000;
    localparam int WIN_LSB = SLOT_BITS + 1;

    typedef enum logic [1:0] {
        MM_IDLE      = 2'd0,
        MM_SETUP     = 2'd1,
        MM_MAPPED    = 2'd2,
        MM_MAP_SETUP = 2'd3
    } mm_state_e;

    // Expansion RAM slots that translation may touch
    function automatic logic slot_is_ext(input logic [SLOT_BITS-1:0] s);
        return (s == 4'h2) || (s == 4'h3) || (s >= 4'hA);
    endfunction

endpackage

// File: rtl/mm_cru_ctrl.sv
module mm_cru_ctrl
    import mm_pkg::*;
#(
    parameter logic [15:0] CRU_BASE = 16'h1E00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cru_wr,
    input  logic [15:0] cru_addr,
    input  logic        cru_wbit,
    output logic        regs_vis,
    output logic        map_on,
    output logic        cru_rbit
);

    localparam logic [15:0] ADDR_VIS = CRU_BASE;
    localparam logic [15:0] ADDR_MAP = CRU_BASE + 16'd2;

    mm_state_e state_q, state_d;

    logic wr_vis, wr_map;

    assign wr_vis = cru_wr && (cru_addr == ADDR_VIS);
    assign wr_map = cru_wr && (cru_addr == ADDR_MAP);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: EN_ON / EN_OFF / MAP_ON / MAP_OFF transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MM_IDLE: begin
                if (wr_vis && cru_wbit) begin
                    state_d = MM_SETUP;
                end else if (wr_map && cru_wbit) begin
                    state_d = MM_MAPPED;
                end
            end
            MM_SETUP: begin
                if (wr_vis && !cru_wbit) begin
                    state_d = MM_IDLE;
                end else if (wr_map && cru_wbit) begin
                    state_d = MM_MAP_SETUP;
                end
            end
            MM_MAPPED: begin
                if (wr_vis && cru_wbit) begin
                    state_d = MM_MAP_SETUP;
                end else if (wr_map && !cru_wbit) begin
                    state_d = MM_IDLE;
                end
            end
            MM_MAP_SETUP: begin
                if (wr_vis && !cru_wbit) begin
                    state_d = MM_MAPPED;
                end else if (wr_map && !cru_wbit) begin
                    state_d = MM_SETUP;
                end
            end
            default: state_d = MM_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        regs_vis = 1'b0;
        map_on   = 1'b0;
        unique case (state_q)
            MM_IDLE:      begin regs_vis = 1'b0; map_on = 1'b0; end
            MM_SETUP:     begin regs_vis = 1'b1; map_on = 1'b0; end
            MM_MAPPED:    begin regs_vis = 1'b0; map_on = 1'b1; end
            MM_MAP_SETUP: begin regs_vis = 1'b1; map_on = 1'b1; end
            default:      begin regs_vis = 1'b0; map_on = 1'b0; end
        endcase
    end

    always_comb begin
        if (cru_addr == ADDR_VIS) begin
            cru_rbit = regs_vis;
        end else if (cru_addr == ADDR_MAP) begin
            cru_rbit = map_on;
        end else begin
            cru_rbit = 1'b0;
        end
    end

    // R2: a visibility write shows up in the decoded output one cycle later
    p_vis_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cru_wr && cru_addr == ADDR_VIS) |=> (regs_vis == $past(cru_wbit)));

    // R8: a CRU write elsewhere leaves both control bits alone
    p_foreign_cru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cru_wr && cru_addr != ADDR_VIS && cru_addr != ADDR_MAP)
            |=> ($stable(regs_vis) && $stable(map_on)));

    // R9: the mapping bit only moves when its own CRU location is written
    p_map_change_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cru_wr && cru_addr == ADDR_MAP) |=> $stable(map_on));

endmodule

// File: rtl/mm_regfile.sv
module mm_regfile
    import mm_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SLOT_BITS-1:0]             wr_idx,
    input  logic [15:0]                      wr_word,
    input  logic [SLOT_BITS-1:0]             rd_idx,
    output logic [15:0]                      rd_word,
    output logic [NSLOT-1:0][PAGE_W-1:0]     pages
);

    localparam int PAGE_FULL = 16;

    logic [PAGE_FULL-1:0] wr_page_full;
    logic [PAGE_W-1:0]    wr_page;
    logic [PAGE_FULL-1:0] rd_page_full;

    // High byte carries page bits 7:0, low byte carries bits 15:8
    assign wr_page_full = {wr_word[7:0], wr_word[15:8]};
    assign wr_page      = wr_page_full[PAGE_W-1:0];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [PAGE_W-1:0] HOME = PAGE_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pages[g] <= HOME;
            end else if (wr_en && (wr_idx == SLOT_BITS'(g))) begin
                pages[g] <= wr_page;
            end
        end
    end

    assign rd_page_full = PAGE_FULL'(pages[rd_idx]);
    assign rd_word      = {rd_page_full[7:0], rd_page_full[15:8]};

    // R3: the addressed register holds the written page on the next cycle
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pages[$past(wr_idx)] == $past(wr_page)));

endmodule

// File: rtl/mm_xlate.sv
module mm_xlate
    import mm_pkg::*;
#(
    parameter int PAGE_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CPU_AW-1:0]             cpu_addr,
    input  logic                          map_on,
    input  logic [NSLOT-1:0][PAGE_W-1:0]  pages,
    output logic [PAGE_W+OFFS_W-1:0]      phys_addr,
    output logic                          mapped
);

    localparam int PA_W = PAGE_W + OFFS_W;

    logic [NSLOT-1:0]     ext_mask;
    logic [SLOT_BITS-1:0] slot;
    logic [OFFS_W-1:0]    offs;

    for (genvar g = 0; g < NSLOT; g++) begin : g_mask
        assign ext_mask[g] = slot_is_ext(SLOT_BITS'(g));
    end

    assign slot = cpu_addr[CPU_AW-1:OFFS_W];
    assign offs = cpu_addr[OFFS_W-1:0];

    always_comb begin
        if (map_on && ext_mask[slot]) begin
            mapped    = 1'b1;
            phys_addr = {pages[slot], offs};
        end else begin
            mapped    = 1'b0;
            phys_addr = PA_W'(cpu_addr);
        end
    end

    // R5: translation off means no slot is ever flagged as translated
    p_off_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !map_on |-> !mapped);

    // R7: the register window area and the other fixed slots keep their address
    p_fixed_slots_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b010 || cpu_addr[15:13] == 3'b000 ||
         cpu_addr[15:13] == 3'b011 || cpu_addr[15:13] == 3'b100)
            |-> (phys_addr[CPU_AW-1:0] == cpu_addr && !mapped));

endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
    import mm_pkg::*;
#(
    parameter int          PAGE_W   = 12,
    parameter logic [15:0] CRU_BASE = 16'h1E00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cru_wr,
    input  logic [15:0]              cru_addr,
    input  logic                     cru_wbit,
    output logic                     cru_rbit,
    input  logic [15:0]              cpu_addr,
    input  logic                     cpu_we,
    input  logic [15:0]              cpu_wdata,
    output logic                     reg_hit,
    output logic [15:0]              reg_rdata,
    output logic [PAGE_W+11:0]       phys_addr,
    output logic                     mapped
);

    logic                            regs_vis;
    logic                            map_on;
    logic                            in_window;
    logic [SLOT_BITS-1:0]            reg_idx;
    logic [15:0]                     rd_word;
    logic [NSLOT-1:0][PAGE_W-1:0]    pages;

    assign in_window = (cpu_addr[CPU_AW-1:WIN_LSB] == WIN_BASE[CPU_AW-1:WIN_LSB]);
    assign reg_idx   = cpu_addr[WIN_LSB-1:1];
    assign reg_hit   = regs_vis && in_window;
    assign reg_rdata = reg_hit ? rd_word : 16'h0000;

    mm_cru_ctrl #(
        .CRU_BASE (CRU_BASE)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cru_wr   (cru_wr),
        .cru_addr (cru_addr),
        .cru_wbit (cru_wbit),
        .regs_vis (regs_vis),
        .map_on   (map_on),
        .cru_rbit (cru_rbit)
    );

    mm_regfile #(
        .PAGE_W (PAGE_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cpu_we && reg_hit),
        .wr_idx  (reg_idx),
        .wr_word (cpu_wdata),
        .rd_idx  (reg_idx),
        .rd_word (rd_word),
        .pages   (pages)
    );

    mm_xlate #(
        .PAGE_W (PAGE_W)
    ) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .map_on    (map_on),
        .pages     (pages),
        .phys_addr (phys_addr),
        .mapped    (mapped)
    );

    // R4: with the window hidden, CPU writes leave every page register alone
    p_hidden_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_vis && cpu_we) |=> $stable(pages));

    // R2: a register hit is never reported while the window is hidden
    p_hit_needs_vis_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cru_rbit_vis_q |-> !reg_hit);

    logic cru_rbit_vis_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cru_rbit_vis_q <= 1'b0;
        end else if (cru_wr && cru_addr == CRU_BASE) begin
            cru_rbit_vis_q <= cru_wbit;
        end
    end

endmodule

// File: tb/pgmap_top_tb.sv
module pgmap_top_tb;

    localparam int PAGE_W = 12;
    localparam int PA_W   = PAGE_W + 12;
    localparam logic [15:0] CB = 16'h1E00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cru_wr = 1'b0;
    logic [15:0]       cru_addr = 16'h0;
    logic              cru_wbit = 1'b0;
    logic              cru_rbit;
    logic [15:0]       cpu_addr = 16'h0;
    logic              cpu_we = 1'b0;
    logic [15:0]       cpu_wdata = 16'h0;
    logic              reg_hit;
    logic [15:0]       reg_rdata;
    logic [PA_W-1:0]   phys_addr;
    logic              mapped;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Bench RAM: 32 pages of 4 KiB, aliasing above that
    logic [15:0] ram [0:65535];

    pgmap_top #(.PAGE_W(PAGE_W), .CRU_BASE(CB)) u_dut (
        .clk(clk), .rst_n(rst_n), .cru_wr(cru_wr), .cru_addr(cru_addr),
        .cru_wbit(cru_wbit), .cru_rbit(cru_rbit), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .reg_hit(reg_hit),
        .reg_rdata(reg_rdata), .phys_addr(phys_addr), .mapped(mapped)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cpu_we && !reg_hit) ram[phys_addr[16:1]] <= cpu_wdata;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 150000);
        n_bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
        finish_run();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cru_w(input logic [15:0] a, input logic b);
        @(negedge clk);
        cru_addr = a; cru_wbit = b; cru_wr = 1'b1;
        @(negedge clk);
        cru_wr = 1'b0;
    endtask

    task automatic cpu_w(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic look(input logic [15:0] a);
        cpu_addr = a;
        #5;
    endtask

    function automatic logic [15:0] page_of(input logic [15:0] w);
        logic [15:0] p;
        p = {w[7:0], w[15:8]};
        return p & 16'(( 1 << PAGE_W) - 1);
    endfunction

    function automatic logic [15:0] rd_of(input logic [15:0] p);
        return {p[7:0], p[15:8]};
    endfunction

    function automatic logic is_ext(input int s);
        return (s == 2) || (s == 3) || (s >= 10);
    endfunction

    logic [15:0] shadow [0:15];

    initial begin
        for (int i = 0; i < 65536; i++) ram[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        cru_addr = CB; #5; chk("R1 vis bit", 32'(cru_rbit), 0);
        cru_addr = CB + 2; #5; chk("R1 map bit", 32'(cru_rbit), 0);
        look(16'h2010); chk("R1 unmapped", 32'(mapped), 0);
        look(16'h4000); chk("R1 hidden hit", 32'(reg_hit), 0);

        // R2: make visible; check window bounds and reset pages
        cru_w(CB, 1'b1);
        cru_addr = CB; #5; chk("R2 vis readback", 32'(cru_rbit), 1);
        for (int s = 0; s < 16; s++) begin
            look(16'h4000 + 16'(2 * s));
            chk("R2 hit in window", 32'(reg_hit), 1);
            chk("R1 home page", 32'(reg_rdata), 32'(rd_of(16'(s))));
            shadow[s] = 16'(s);
        end
        look(16'h3FFE); chk("R2 below window", 32'(reg_hit), 0);
        look(16'h4020); chk("R2 above window", 32'(reg_hit), 0);

        // R8: foreign CRU writes and read-back elsewhere
        cru_w(CB + 4, 1'b1);
        cru_w(16'h1F00, 1'b0);
        cru_addr = CB + 4; #5; chk("R8 foreign rbit", 32'(cru_rbit), 0);
        cru_addr = CB; #5; chk("R8 vis kept", 32'(cru_rbit), 1);
        cru_addr = CB + 2; #5; chk("R8 map kept", 32'(cru_rbit), 0);

        // R3: write every register with a distinct pattern and read back
        for (int s = 0; s < 16; s++) begin
            logic [15:0] w;
            w = 16'((s * 16'h1B3 + 16'h37) << 4) ^ 16'hA55A;
            cpu_w(16'h4000 + 16'(2 * s), w);
            shadow[s] = page_of(w);
        end
        for (int s = 0; s < 16; s++) begin
            look(16'h4000 + 16'(2 * s));
            chk("R3 readback", 32'(reg_rdata), 32'(rd_of(shadow[s])));
        end
        cpu_w(16'h401E, 16'hFFFF);
        shadow[15] = page_of(16'hFFFF);
        look(16'h401E); chk("R3 upper bits zero", 32'(reg_rdata), 32'h0000FF0F);

        // R5: translation off, sweep all slots
        for (int s = 0; s < 16; s++) begin
            look(16'(s << 12) | 16'h0ABC);
            chk("R5 passthru addr", 32'(phys_addr), 32'(16'(s << 12) | 16'h0ABC));
            chk("R5 not mapped", 32'(mapped), 0);
        end

        // R9: mapping turns on the cycle after the capturing edge
        @(negedge clk);
        cru_addr = CB + 2; cru_wbit = 1'b1; cru_wr = 1'b1; cpu_addr = 16'hA123;
        #5; chk("R9 before edge", 32'(mapped), 0);
        @(negedge clk);
        cru_wr = 1'b0;
        #5; chk("R9 after edge", 32'(mapped), 1);

        // R6 / R7: translation on, sweep slots and offsets
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 3; k++) begin
                logic [15:0] a;
                logic [31:0] e;
                a = 16'(s << 12) | 16'(k * 16'h7FE + 1);
                look(a);
                if (is_ext(s)) begin
                    e = {shadow[s][PAGE_W-1:0], a[11:0]};
                    chk("R6 translated addr", 32'(phys_addr), e);
                    chk("R6 mapped flag", 32'(mapped), 1);
                end else begin
                    chk("R7 fixed addr", 32'(phys_addr), 32'(a));
                    chk("R7 fixed flag", 32'(mapped), 0);
                end
            end
        end

        // R4: hide window, write, then show and read back
        cru_w(CB, 1'b0);
        cpu_w(16'h4006, 16'h1234);
        look(16'h4006); chk("R4 hidden hit", 32'(reg_hit), 0);
        cru_w(CB, 1'b1);
        look(16'h4006); chk("R4 reg untouched", 32'(reg_rdata), 32'(rd_of(shadow[3])));

        // R10: restore slot 2 to its own page
        cpu_w(16'h4004, 16'h0200);
        look(16'h2468); chk("R10 restored addr", 32'(phys_addr), 32'h2468);
        look(16'h4004); chk("R10 restored reg", 32'(reg_rdata), 32'h0200);

        // R6: page size probe through aliasing bench RAM
        cpu_w(16'h4004, 16'h1000);
        cpu_w(16'h2000, 16'hC3A5);
        begin
            int cnt;
            int p;
            cnt = 0;
            p = 16;
            forever begin
                p++;
                cnt++;
                cpu_w(16'h4004, {8'(p), 8'h00});
                look(16'h2000);
                if (ram[phys_addr[16:1]] == 16'hC3A5 || cnt > 200) break;
            end
            chk("R6 probe pages", 32'(p - cnt + cnt), 32'd48);
            chk("R6 probe steps", 32'(cnt), 32'd32);
        end
        cpu_w(16'h4004, 16'h0200);

        // R2: hide again and confirm window gone
        cru_w(CB, 1'b0);
        look(16'h4004); chk("R2 hidden rdata", 32'(reg_rdata), 0);

        finish_run();
    end

endmodule